// File: doc/BRIEF.md
# Column-Counter Unsigned Multiplier

This block multiplies two unsigned operands and returns the full double-width product. AND gates form every partial-product bit. The sum is then built one bit column at a time, from the least significant column to the most significant. Each column has a single wide binary counter. That counter takes the column's partial-product bits and every count bit passed up from lower columns. No full-adder tree is used.

Bit 0 of a column's count is the product bit for that column. Count bit k of column j is sent on as one extra input of column j+k. The counter width for each column is worked out at elaboration time as ceil(log2(n+1)), where n is the number of inputs that column receives. Widths therefore grow towards the middle of the array and fall again near the top. With the default 24x24 size, the busiest column counts 28 inputs into 5 bits.

The datapath has no clock. A parameter can place a register on the product, and that register has a synchronous active-low reset. The block is meant to hold the significand multiply of a single-precision floating-point unit. It can also serve as a general unsigned multiplier.

Top module: `col_compress_mult`

## Requirements
- R1: `prod` equals the exact unsigned product `a*b`, with all PW = AW+BW bits, for every pair of operands.
- R2: If either operand is zero, `prod` is zero.
- R3: If both operands are all ones, `prod` is (2^AW-1)*(2^BW-1). For the 24x24 default this is 48'hFFFFFE000001.
- R4: If `a` = 2^i and `b` = 2^k, exactly one bit of `prod` is set, and it is bit i+k. This includes the top set bit, i+k = PW-2.
- R5: If `a` = 1, `prod` equals `b` zero-extended. If `b` = 1, `prod` equals `a` zero-extended.
- R6: Bit 0 of `prod` equals `a[0] & b[0]`. It comes from the lowest column with no adder in its path.
- R7: A count bit that would be routed to a column at or above PW is zero for every input.
- R8: When OUT_REG = 1, `prod` shows the product of the operands present at the previous rising edge of `clk`. A rising edge with `rst_n` low sets `prod` to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Synchronous active-low reset of the output register |
| a | input | AW | Unsigned multiplicand |
| b | input | BW | Unsigned multiplier |
| prod | output | AW+BW | Unsigned product |

## Verification
The bench targets the cases where the column wiring would break first:
- **All-ones operands** load every column with its maximum count. If a counter is too narrow, or a count bit is routed to the wrong column, the upper product bits come out wrong.
- **Single-bit operands** walk one set bit through every column position. A carry sent one column too far or too short shows up as a shifted or missing bit.
- **Zero and unit operands** expose stray constant inputs and mis-indexed partial products.
- **The top set bit (i+k = PW-2)** and many random vectors catch a missing top column or a dropped final carry.
- **The reset check** catches a register that does not clear.

// File: rtl/cmul_pkg.sv
// Package: compile-time helpers for the column-counter multiplier.
// It sizes every column's counter and gives one shared population count.
// Assumes the product is no wider than CMUL_MAXCOL bits.
package cmul_pkg;

    localparam int CMUL_MAXCOL = 256;
    localparam int CMUL_POPW   = 256;

    // Width of a counter that must hold the values 0..n.
    function automatic int cnt_width(input int n);
        int w;
        w = 1;
        while ((1 << w) <= n) w++;
        return w;
    endfunction

    // Number of AND-gate partial products that land in column j.
    function automatic int pp_in_col(input int j, input int aw, input int bw);
        int c;
        c = 0;
        for (int i = 0; i < aw; i++)
            if ((j - i) >= 0 && (j - i) < bw) c++;
        return c;
    endfunction

    // Total inputs of column j: its partial products plus the count bits
    // sent up from lower columns (bit k of column c goes to column c+k).
    function automatic int col_inputs(input int j, input int aw, input int bw);
        int n [CMUL_MAXCOL];
        for (int c = 0; c <= j; c++) begin
            n[c] = pp_in_col(c, aw, bw);
            for (int k = 1; k <= c; k++)
                if (k < cnt_width(n[c - k])) n[c]++;
        end
        return n[j];
    endfunction

    // Counter width of column j.
    function automatic int col_width(input int j, input int aw, input int bw);
        return cnt_width(col_inputs(j, aw, bw));
    endfunction

    // Widest counter anywhere in the array.
    function automatic int max_width(input int aw, input int bw);
        int m;
        m = 1;
        for (int j = 0; j < aw + bw; j++)
            if (col_width(j, aw, bw) > m) m = col_width(j, aw, bw);
        return m;
    endfunction

    // Population count shared by every column counter.
    function automatic int popcnt(input logic [CMUL_POPW-1:0] v);
        int s;
        s = 0;
        for (int i = 0; i < CMUL_POPW; i++) s += int'(v[i]);
        return s;
    endfunction

endpackage

// File: rtl/cmul_pp_matrix.sv
// Module: cmul_pp_matrix
// Builds the AW x BW partial-product matrix, one AND gate per bit.
// Row i, column k holds a[i] & b[k]; that bit has weight 2^(i+k).
module cmul_pp_matrix #(
    parameter int AW = 24,
    parameter int BW = 24
) (
    input  logic [AW-1:0]         a,
    input  logic [BW-1:0]         b,
    output logic [AW-1:0][BW-1:0] pp
);
    for (genvar i = 0; i < AW; i++) begin : g_row
        for (genvar k = 0; k < BW; k++) begin : g_bit
            // One partial-product bit.
            assign pp[i][k] = a[i] & b[k];
        end
    end
endmodule

// File: rtl/cmul_col_counter.sv
// Module: cmul_col_counter
// An N-input counter: outputs the binary number of ones among its inputs.
// Assumes N <= 256 and that W can hold the value N.
module cmul_col_counter #(
    parameter int N = 4,
    parameter int W = 3
) (
    input  logic [N-1:0] bits,
    output logic [W-1:0] count
);
    import cmul_pkg::*;

    // Count the ones in the column.
    always_comb begin
        count = W'(popcnt(CMUL_POPW'(bits)));
    end
endmodule

// File: rtl/cmul_col_tree.sv
// Module: cmul_col_tree
// Sums the partial-product matrix one column at a time.
// Column j counts its partial products plus every count bit passed up
// from below. Bit 0 of its count is product bit j, and count bit k is
// sent to column j+k. Count bits that would go at or above PW are
// gathered on 'spill'; they are zero whenever the wiring is correct.
module cmul_col_tree #(
    parameter int AW = 24,
    parameter int BW = 24
) (
    input  logic [AW-1:0][BW-1:0] pp,
    output logic [AW+BW-1:0]      prod,
    output logic                  spill
);
    import cmul_pkg::*;

    localparam int PW   = AW + BW;
    localparam int CWMX = max_width(AW, BW);

    // Selects every count bit whose destination column is PW or higher.
    function automatic logic [PW*CWMX-1:0] spill_sel();
        logic [PW*CWMX-1:0] m;
        m = '0;
        for (int j = 0; j < PW; j++)
            for (int k = 1; k < col_width(j, AW, BW); k++)
                if (j + k >= PW) m[j*CWMX + k] = 1'b1;
        return m;
    endfunction

    localparam logic [PW*CWMX-1:0] SPILL_MASK = spill_sel();

    // Count of every column, in slices CWMX bits wide.
    logic [PW*CWMX-1:0] cnt_flat;

    for (genvar j = 0; j < PW; j++) begin : g_col
        localparam int NIN  = col_inputs(j, AW, BW);
        localparam int W    = cnt_width(NIN);
        localparam int CARW = (j == 0) ? 1 : j;

        logic [AW-1:0]   pbit;
        logic [CARW-1:0] car;
        logic [W-1:0]    c;

        for (genvar i = 0; i < AW; i++) begin : g_pp
            if ((j - i) >= 0 && (j - i) < BW) begin : g_on
                // Partial product a[i]&b[j-i] feeds this column.
                assign pbit[i] = pp[i][j-i];
            end else begin : g_off
                assign pbit[i] = 1'b0;
            end
        end

        if (j == 0) begin : g_nocar
            assign car = '0;
        end else begin : g_car
            for (genvar k = 1; k <= j; k++) begin : g_k
                if (k < col_width(j - k, AW, BW)) begin : g_on
                    // Count bit k of column j-k arrives here.
                    assign car[k-1] = cnt_flat[(j-k)*CWMX + k];
                end else begin : g_off
                    assign car[k-1] = 1'b0;
                end
            end
        end

        cmul_col_counter #(.N(AW + CARW), .W(W)) u_cnt (
            .bits  ({car, pbit}),
            .count (c)
        );

        if (W < CWMX) begin : g_pad
            assign cnt_flat[j*CWMX +: CWMX] = {{(CWMX-W){1'b0}}, c};
        end else begin : g_full
            assign cnt_flat[j*CWMX +: CWMX] = c;
        end

        // The product bit is the count's least significant bit.
        assign prod[j] = c[0];
    end

    // Collect count bits that fall off the top of the product.
    assign spill = |(cnt_flat & SPILL_MASK);
endmodule

// File: rtl/col_compress_mult.sv
// Module: col_compress_mult (top)
// Unsigned AW x BW multiplier built from one counter per column.
// With OUT_REG = 1 the product is registered: synchronous, active-low
// reset, latency one clock. With OUT_REG = 0 it is purely combinational.
module col_compress_mult #(
    parameter int AW      = 24,
    parameter int BW      = 24,
    parameter bit OUT_REG = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [AW-1:0]      a,
    input  logic [BW-1:0]      b,
    output logic [AW+BW-1:0]   prod
);
    localparam int PW = AW + BW;

    logic [AW-1:0][BW-1:0] pp;
    logic [PW-1:0]         sum;
    logic                  spill;

    cmul_pp_matrix #(.AW(AW), .BW(BW)) u_pp (
        .a  (a),
        .b  (b),
        .pp (pp)
    );

    cmul_col_tree #(.AW(AW), .BW(BW)) u_tree (
        .pp    (pp),
        .prod  (sum),
        .spill (spill)
    );

    // R7
    top_spill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spill == 1'b0);

    if (OUT_REG) begin : g_reg
        // Register the product; synchronous active-low clear.
        always_ff @(posedge clk) begin
            if (!rst_n) prod <= '0;
            else        prod <= sum;
        end

        // R2
        zero_operand_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (a == '0 || b == '0) |=> prod == '0);
        // R5
        unit_operand_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (a == AW'(1)) |=> prod == PW'($past(b)));
        // R6
        lsb_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> prod[0] == ($past(a[0]) & $past(b[0])));
        // R1
        top_bits_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!a[AW-1] && !b[BW-1]) |=> prod[PW-1:PW-2] == 2'b00);
    end else begin : g_comb
        // Pass the product straight through.
        always_comb prod = sum;

        // R2
        zero_operand_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (a == '0 || b == '0) |-> prod == '0);
        // R6
        lsb_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
            prod[0] == (a[0] & b[0]));
        // R1
        top_bits_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!a[AW-1] && !b[BW-1]) |-> prod[PW-1:PW-2] == 2'b00);
    end
endmodule

// File: tb/col_compress_mult_test.sv
// Bench for col_compress_mult at default parameters (registered output).
module col_compress_mult_test;
    localparam int AW = 24;
    localparam int BW = 24;
    localparam int PW = AW + BW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] a = '0;
    logic [BW-1:0] b = '0;
    logic [PW-1:0] prod;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    col_compress_mult #(.AW(AW), .BW(BW), .OUT_REG(1'b1)) uut (
        .clk   (clk),
        .rst_n (rst_n),
        .a     (a),
        .b     (b),
        .prod  (prod)
    );

    always #5 clk = ~clk;

    // Reference product, computed at full width.
    function automatic logic [PW-1:0] ref_mul(input logic [AW-1:0] x, input logic [BW-1:0] y);
        return PW'(x) * PW'(y);
    endfunction

    task automatic check(input string req, input logic [PW-1:0] got, input logic [PW-1:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Drive operands at a falling edge; one register later, sample at the next falling edge.
    task automatic apply(input string req, input logic [AW-1:0] x, input logic [BW-1:0] y);
        @(negedge clk);
        a = x;
        b = y;
        @(negedge clk);
        check(req, prod, ref_mul(x, y));
    endtask

    initial begin
        int unsigned seed;
        seed = 32'd1234;
        void'($urandom(seed));
        // R8: reset clears the register even though the operands are nonzero.
        a = '1;
        b = '1;
        repeat (3) @(negedge clk);
        check("R8 reset", prod, '0);
        rst_n = 1'b1;
        // R8: one-cycle latency, reference -18.0 * 9.5 significands.
        apply("R8 latency", 24'h900000, 24'h980000);
        apply("R1 sig", 24'h900000, 24'h980000);
        // R2: zero operands.
        apply("R2 zero a", '0, 24'hABCDEF);
        apply("R2 zero b", 24'h123456, '0);
        apply("R2 both", '0, '0);
        // R3: every column at its maximum load.
        apply("R3 ones", '1, '1);
        check("R3 const", prod, 48'hFFFFFE000001);
        // R5: unit operands.
        apply("R5 a=1", 24'd1, 24'hF0F0F1);
        apply("R5 b=1", 24'hC3C3C3, 24'd1);
        // R6: lowest column.
        apply("R6 lsb", 24'h000001, 24'h000003);
        // R4: single set bits walked across every column.
        for (int i = 0; i < AW; i++) begin
            apply("R4 bit", AW'(1) << i, BW'(1) << i);
            check("R4 onehot", prod, PW'(1) << (2 * i));
            apply("R4 cross", AW'(1) << i, BW'(1) << (BW - 1 - i));
        end
        apply("R4 top", AW'(1) << (AW - 1), BW'(1) << (BW - 1));
        check("R4 bit46", prod, PW'(1) << (PW - 2));
        // R7: heavy top columns; the product must close at the top bit.
        apply("R7 hi", 24'hFFFFFF, 24'hFFFFFE);
        apply("R7 hi2", 24'hFFFFFE, 24'hFFFFFF);
        // R1: random vectors.
        for (int n = 0; n < 400; n++)
            apply("R1 rand", AW'($urandom()), BW'($urandom()));
        // R1: random vectors with dense ones.
        for (int n = 0; n < 100; n++)
            apply("R1 dense", AW'($urandom() | $urandom()), BW'($urandom() | $urandom()));
        // R8: reset asserted mid-run clears the product again.
        @(negedge clk);
        a = '1;
        b = '1;
        rst_n = 1'b0;
        @(negedge clk);
        check("R8 reclear", prod, '0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule